// File: doc/BRIEF.md
# Exhaustive Block-Matching Motion Search

This engine finds the motion vector of one square pixel block by trying every integer displacement inside a bounded search window. Software or an upstream loader first fills two small local stores through a single pixel write port. One store holds the current block. The other holds the search window that surrounds it. A start pulse then launches the search.

The engine walks through all candidate displacements. It computes one absolute pixel difference per clock and adds it into a sum-of-absolute-differences accumulator. Each finished candidate sum is compared against a running minimum. When the last candidate has been compared, the engine holds the best vector and its distortion on its outputs and raises a one-cycle done pulse.

The write port is valid/ready. `wr_ready` is high exactly when no search is running. A write completes on a clock edge where `wr_valid` and `wr_ready` are both high. While a search runs, the port applies back-pressure by holding `wr_ready` low. A producer must then keep its word stable until ready returns. A write offered during that time has no effect on the stores.

Top module: `sad_motion_search`

## Requirements
- R1: For each displacement (m,n), the distortion is the sum over block rows i and columns j (0-based) of |cur(i,j) − win(i+m+RNG, j+n+RNG)|. After a search, `sad_min` equals the smallest distortion over all candidates.
- R2: Candidates are visited with the vertical displacement m as the outer loop and the horizontal displacement n as the inner loop, both from −RNG up to +RNG. When several candidates share the minimum, the earliest one in this order is reported.
- R3: The distortion path is wide enough for BLK²·(2^PIX_W−1) without wrap-around: 12 bits at the defaults, where an all-255 block over an all-0 window reports 4080.
- R4: Each accepted start sets the running minimum to all ones and the vector to (0,0). A candidate replaces them only when its distortion is strictly lower.
- R5: `done` is a single-cycle pulse. It appears exactly (2·RNG+1)²·BLK²+1 clock cycles after the edge that accepted start (401 cycles at the defaults). `busy` is high in every cycle in between and low in the done cycle.
- R6: A start pulse that arrives while `busy` is high is ignored. It neither restarts nor prolongs the running search.
- R7: A write takes effect on a rising edge only when `wr_valid` and `wr_ready` are both high, and `wr_ready` is high exactly when `busy` is low. A write offered during a search changes no stored pixel. A write and a start in the same idle cycle both take effect, and the search sees the written pixel.
- R8: With `wr_sel`=1 the address is row·WIN+col of the window, where WIN=2·RNG+BLK and row 0 is the top, that is displacement −RNG. With `wr_sel`=0 the address is row·BLK+col of the block, and block addresses at or above BLK² are ignored.
- R9: `mv_row` carries m and `mv_col` carries n. Both are two's-complement, $clog2(2·RNG+1)+1 bits wide (4 bits at the defaults), and lie within ±RNG.
- R10: After reset, `busy` and `done` are low, `wr_ready` is high, `sad_min` is all ones and both vector outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Pixel write offered |
| wr_ready | output | 1 | Pixel write can be taken (engine idle) |
| wr_sel | input | 1 | 0 selects the block store, 1 selects the window store |
| wr_addr | input | $clog2(WIN·WIN) | Row-major pixel address |
| wr_data | input | PIX_W | Pixel value |
| start | input | 1 | Launch a search (taken only when idle) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result pulse |
| mv_row | output | MV_W | Best vertical displacement, signed |
| mv_col | output | MV_W | Best horizontal displacement, signed |
| sad_min | output | SAD_W | Distortion of the best candidate |

## Verification
Two functions can fall in the same cycle: a pixel write can be accepted on the very edge that accepts start, and a start can arrive while a search is running alongside a write that back-pressure must hold off. The bench provokes the first by asserting start together with the last block write. It judges the case by a result that depends on that last pixel. It provokes the second by pulsing start and holding a write of garbage in the middle of a search. It judges that case by the unchanged done timing and by the next search, which still returns results computed from the original pixels.

// File: rtl/me_pkg.sv
package me_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_FIN  = 2'd2
  } me_state_e;
endpackage

// File: rtl/me_scan_ctrl.sv
module me_scan_ctrl
  import me_pkg::*;
#(
  parameter int BLK  = 4,
  parameter int CAND = 5,
  localparam int IW  = (BLK  > 1) ? $clog2(BLK)  : 1,
  localparam int OW  = (CAND > 1) ? $clog2(CAND) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          launch,
  output logic          busy,
  output logic          acc_en,
  output logic          last_pix,
  output logic [IW-1:0] pi,
  output logic [IW-1:0] pj,
  output logic [OW-1:0] om,
  output logic [OW-1:0] on,
  output logic          done
);
  me_state_e state;
  logic      last_cand;

  assign launch    = start && (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign acc_en    = (state == ST_ACC);
  assign last_pix  = (pi == IW'(BLK - 1)) && (pj == IW'(BLK - 1));
  assign last_cand = last_pix && (om == OW'(CAND - 1)) && (on == OW'(CAND - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pi    <= '0;
      pj    <= '0;
      om    <= '0;
      on    <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_ACC;
            pi    <= '0;
            pj    <= '0;
            om    <= '0;
            on    <= '0;
          end
        end
        ST_ACC: begin
          if (pj == IW'(BLK - 1)) begin
            pj <= '0;
            if (pi == IW'(BLK - 1)) begin
              pi <= '0;
              if (on == OW'(CAND - 1)) begin
                on <= '0;
                om <= om + 1'b1;
              end else begin
                on <= on + 1'b1;
              end
            end else begin
              pi <= pi + 1'b1;
            end
          end else begin
            pj <= pj + 1'b1;
          end
          if (last_cand) state <= ST_FIN;
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/me_sad_acc.sv
module me_sad_acc #(
  parameter int PIX_W = 8,
  parameter int SAD_W = 12,
  parameter int OW    = 3,
  parameter int RNG   = 2,
  localparam int MV_W = OW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    acc_en,
  input  logic                    last_pix,
  input  logic [PIX_W-1:0]        cur_px,
  input  logic [PIX_W-1:0]        win_px,
  input  logic [OW-1:0]           om,
  input  logic [OW-1:0]           on,
  output logic                    cand_vld,
  output logic [SAD_W-1:0]        cand_sad,
  output logic signed [MV_W-1:0]  cand_m,
  output logic signed [MV_W-1:0]  cand_n
);
  logic [PIX_W-1:0] ad;
  logic [SAD_W-1:0] acc;
  logic [SAD_W-1:0] sum;
  logic signed [MV_W-1:0] rng_s;

  assign rng_s = MV_W'(RNG);
  assign ad    = (cur_px > win_px) ? (cur_px - win_px) : (win_px - cur_px);
  assign sum   = acc + SAD_W'(ad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      cand_vld <= 1'b0;
      cand_sad <= '0;
      cand_m   <= '0;
      cand_n   <= '0;
    end else begin
      cand_vld <= 1'b0;
      if (clear) begin
        acc <= '0;
      end else if (acc_en) begin
        if (last_pix) begin
          acc      <= '0;
          cand_vld <= 1'b1;
          cand_sad <= sum;
          cand_m   <= signed'({1'b0, om}) - rng_s;
          cand_n   <= signed'({1'b0, on}) - rng_s;
        end else begin
          acc <= sum;
        end
      end
    end
  end
endmodule

// File: rtl/me_min_select.sv
module me_min_select #(
  parameter int SAD_W = 12,
  parameter int MV_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   init,
  input  logic                   cand_vld,
  input  logic [SAD_W-1:0]       cand_sad,
  input  logic signed [MV_W-1:0] cand_m,
  input  logic signed [MV_W-1:0] cand_n,
  output logic [SAD_W-1:0]       best_sad,
  output logic signed [MV_W-1:0] best_m,
  output logic signed [MV_W-1:0] best_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_sad <= '1;
      best_m   <= '0;
      best_n   <= '0;
    end else if (init) begin
      best_sad <= '1;
      best_m   <= '0;
      best_n   <= '0;
    end else if (cand_vld && (cand_sad < best_sad)) begin
      best_sad <= cand_sad;
      best_m   <= cand_m;
      best_n   <= cand_n;
    end
  end
endmodule

// File: rtl/sad_motion_search.sv
module sad_motion_search #(
  parameter int PIX_W   = 8,
  parameter int BLK     = 4,
  parameter int RNG     = 2,
  localparam int WIN    = 2 * RNG + BLK,
  localparam int CAND   = 2 * RNG + 1,
  localparam int ADDR_W = $clog2(WIN * WIN),
  localparam int CA_W   = (BLK > 1) ? $clog2(BLK * BLK) : 1,
  localparam int OW     = (CAND > 1) ? $clog2(CAND) : 1,
  localparam int IW     = (BLK > 1) ? $clog2(BLK) : 1,
  localparam int MV_W   = OW + 1,
  localparam int SAD_W  = $clog2(BLK * BLK * ((1 << PIX_W) - 1) + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic                   wr_sel,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [PIX_W-1:0]       wr_data,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  output logic signed [MV_W-1:0] mv_row,
  output logic signed [MV_W-1:0] mv_col,
  output logic [SAD_W-1:0]       sad_min
);
  logic [PIX_W-1:0] cur_mem [BLK*BLK];
  logic [PIX_W-1:0] win_mem [WIN*WIN];

  logic          launch, acc_en, last_pix;
  logic [IW-1:0] pi, pj;
  logic [OW-1:0] om, on;
  logic          cand_vld;
  logic [SAD_W-1:0] cand_sad;
  logic signed [MV_W-1:0] cand_m, cand_n;

  logic [CA_W-1:0]   cidx;
  logic [ADDR_W-1:0] wrow, wcol, widx;
  logic              wr_fire;

  assign wr_ready = !busy;
  assign wr_fire  = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      if (wr_sel) begin
        if ({1'b0, wr_addr} < (ADDR_W + 1)'(WIN * WIN))
          win_mem[wr_addr] <= wr_data;
      end else if ({1'b0, wr_addr} < (ADDR_W + 1)'(BLK * BLK)) begin
        cur_mem[wr_addr[CA_W-1:0]] <= wr_data;
      end
    end
  end

  assign cidx = CA_W'(pi) * CA_W'(BLK) + CA_W'(pj);
  assign wrow = ADDR_W'(pi) + ADDR_W'(om);
  assign wcol = ADDR_W'(pj) + ADDR_W'(on);
  assign widx = wrow * ADDR_W'(WIN) + wcol;

  me_scan_ctrl #(.BLK(BLK), .CAND(CAND)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .launch(launch),
    .busy(busy), .acc_en(acc_en), .last_pix(last_pix),
    .pi(pi), .pj(pj), .om(om), .on(on), .done(done)
  );

  me_sad_acc #(.PIX_W(PIX_W), .SAD_W(SAD_W), .OW(OW), .RNG(RNG)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(launch), .acc_en(acc_en),
    .last_pix(last_pix), .cur_px(cur_mem[cidx]), .win_px(win_mem[widx]),
    .om(om), .on(on), .cand_vld(cand_vld), .cand_sad(cand_sad),
    .cand_m(cand_m), .cand_n(cand_n)
  );

  me_min_select #(.SAD_W(SAD_W), .MV_W(MV_W)) u_min (
    .clk(clk), .rst_n(rst_n), .init(launch), .cand_vld(cand_vld),
    .cand_sad(cand_sad), .cand_m(cand_m), .cand_n(cand_n),
    .best_sad(sad_min), .best_m(mv_row), .best_n(mv_col)
  );
endmodule

// File: rtl/me_checker.sv
module me_checker #(
  parameter int PIX_W = 8,
  parameter int BLK   = 4,
  parameter int RNG   = 2,
  localparam int CAND = 2 * RNG + 1,
  localparam int MV_W = ((CAND > 1) ? $clog2(CAND) : 1) + 1,
  localparam int SAD_W = $clog2(BLK * BLK * ((1 << PIX_W) - 1) + 1),
  localparam int LAT  = CAND * CAND * BLK * BLK + 1,
  localparam int MAXS = BLK * BLK * ((1 << PIX_W) - 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   busy,
  input logic                   done,
  input logic                   wr_ready,
  input logic signed [MV_W-1:0] mv_row,
  input logic signed [MV_W-1:0] mv_col,
  input logic [SAD_W-1:0]       sad_min
);
  int unsigned busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= 0;
    else        busy_len <= busy ? busy_len + 1 : 0;
  end

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_len == LAT));
  assert_busy_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_len < LAT));
  assert_launch_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_ready_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> wr_ready);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sad_min <= SAD_W'(MAXS)));
  assert_mv_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((mv_row >= -MV_W'(RNG)) && (mv_row <= MV_W'(RNG)) &&
              (mv_col >= -MV_W'(RNG)) && (mv_col <= MV_W'(RNG))));
endmodule

bind sad_motion_search me_checker #(.PIX_W(PIX_W), .BLK(BLK), .RNG(RNG)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .wr_ready(wr_ready), .mv_row(mv_row), .mv_col(mv_col), .sad_min(sad_min)
);

// File: tb/sad_motion_search_bench.sv
module sad_motion_search_bench;
  localparam int PIX_W = 8, BLK = 4, RNG = 2;
  localparam int WIN = 2 * RNG + BLK, CAND = 2 * RNG + 1;
  localparam int ADDR_W = 6, MV_W = 4, SAD_W = 12;
  localparam int LAT = CAND * CAND * BLK * BLK + 1;
  localparam int ALL1 = (1 << SAD_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic wr_valid = 1'b0, wr_sel = 1'b0, start = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [PIX_W-1:0]  wr_data = '0;
  logic wr_ready, busy, done;
  logic signed [MV_W-1:0] mv_row, mv_col;
  logic [SAD_W-1:0] sad_min;

  always #5 clk = ~clk;

  sad_motion_search u_sad_motion_search (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data), .start(start),
    .busy(busy), .done(done), .mv_row(mv_row), .mv_col(mv_col), .sad_min(sad_min)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit fin = 0;
  int ref_cur [BLK*BLK];
  int ref_win [WIN*WIN];
  bit m_busy = 0, m_done = 0;
  int m_cnt = 0, e_sad = ALL1, e_r = 0, e_c = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void ref_search();
    e_sad = ALL1; e_r = 0; e_c = 0;
    for (int m = -RNG; m <= RNG; m++)
      for (int n = -RNG; n <= RNG; n++) begin
        int d = 0;
        for (int i = 0; i < BLK; i++)
          for (int j = 0; j < BLK; j++) begin
            int a = ref_cur[i*BLK+j];
            int b = ref_win[(i+m+RNG)*WIN + (j+n+RNG)];
            d += (a > b) ? a - b : b - a;
          end
        if (d < e_sad) begin e_sad = d; e_r = m; e_c = n; end
      end
  endfunction

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    bit was;
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; e_sad = ALL1; e_r = 0; e_c = 0;
    end else begin
      was = m_busy;
      m_done = 0;
      if (!was && wr_valid) begin
        if (wr_sel) ref_win[wr_addr] = wr_data;
        else if (wr_addr < BLK*BLK) ref_cur[wr_addr] = wr_data;
      end
      if (was) begin
        m_cnt++;
        if (m_cnt == LAT) begin m_busy = 0; m_done = 1; end
      end else if (start) begin
        m_busy = 1; m_cnt = 0; ref_search();
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!fin && $time > 2) begin
      string t;
      t = rst_n ? "R5 R6 busy" : "R10 busy";
      chk(busy == m_busy, t, busy, m_busy);
      chk(done == m_done, rst_n ? "R5 done" : "R10 done", done, m_done);
      chk(wr_ready == !m_busy, "R7 ready", wr_ready, !m_busy);
      if (!m_busy) begin
        chk(int'(sad_min) == e_sad, "R1 R3 R4 R8 sad", sad_min, e_sad);
        chk(int'(mv_row) == e_r, "R2 R4 R9 mv_row", mv_row, e_r);
        chk(int'(mv_col) == e_c, "R2 R4 R9 mv_col", mv_col, e_c);
      end
    end
    if (cyc > 100000 && !fin) begin
      fin = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic put(bit s, int a, int d);
    wr_valid = 1'b1; wr_sel = s; wr_addr = ADDR_W'(a); wr_data = PIX_W'(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic go();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  int tw [WIN*WIN];

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R8: block copied out of a random window at (m,n)=(1,-2)
    for (int k = 0; k < WIN*WIN; k++) begin tw[k] = $urandom_range(0, 255); put(1, k, tw[k]); end
    for (int k = 0; k < BLK*BLK; k++) put(0, k, tw[((k/BLK)+1+RNG)*WIN + (k%BLK)-2+RNG]);
    go(); wait_done();

    // R2 R4: flat picture, every candidate ties at 0, earliest (-2,-2) kept
    for (int k = 0; k < WIN*WIN; k++) put(1, k, 77);
    for (int k = 0; k < BLK*BLK; k++) put(0, k, 77);
    go(); wait_done();

    // R3: largest distortion 4080 for every candidate
    for (int k = 0; k < WIN*WIN; k++) put(1, k, 0);
    for (int k = 0; k < BLK*BLK; k++) put(0, k, 255);
    go(); wait_done();

    // R1: fully random data
    for (int k = 0; k < WIN*WIN; k++) put(1, k, $urandom_range(0, 255));
    for (int k = 0; k < BLK*BLK; k++) put(0, k, $urandom_range(0, 255));
    go();
    // R6 R7: start pulse and held garbage writes in mid-search
    repeat (50) @(negedge clk);
    go();
    wr_valid = 1'b1; wr_sel = 1'b1; wr_addr = 6'd27; wr_data = 8'd3;
    repeat (20) @(negedge clk);
    wr_sel = 1'b0; wr_addr = 6'd5;
    repeat (20) @(negedge clk);
    wr_valid = 1'b0;
    wait_done();
    go(); wait_done();  // same stored data must give the same answer

    // R8: block writes at addresses >= 16 are dropped
    for (int k = BLK*BLK; k < 64; k += 7) put(0, k, 200);
    go(); wait_done();

    // R7: final block write in the same cycle as start
    for (int k = 0; k < WIN*WIN; k++) put(1, k, (k * 37) % 256);
    for (int k = 0; k < BLK*BLK - 1; k++) put(0, k, (k * 91) % 256);
    start = 1'b1;
    put(0, BLK*BLK - 1, 250);
    start = 1'b0;
    wait_done();

    repeat (3) @(negedge clk);
    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule